// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Replay

This block is a scratchpad memory split into many single-port banks, shared by a group of lanes that issue one combined request at a time. Every lane carries its own active bit, word address, write enable and write data. The low bits of a word address pick the bank and the remaining bits pick the row inside it. Lanes that land in separate banks are served together in a single pass. Lanes whose addresses share a bank but differ are replayed over extra passes. Lanes that name the same word are merged into one access.

A request is taken when the block is idle and `req_valid` is high. While `busy` is high the block runs one pass per clock. In each bank it picks the lowest-numbered pending lane, and it serves that lane together with every other pending lane in the bank that has the same address. When no lane is left pending, the block raises `done` for one cycle. It then presents the per-lane read data and the number of passes the request took.

Top module: `lane_scratchpad`

## Requirements
- R1: A word address selects bank `addr % BANKS` (its low log2(BANKS) bits) and row `addr / BANKS`. A word written at an address is returned by a later read of that same address.
- R2: When no two active lanes share a bank, the request takes exactly one pass.
- R3: The pass count equals the largest number of distinct addresses that active lanes present to any single bank.
- R4: Active lanes naming the same address are served in the same pass, and each of them receives the stored word.
- R5: An inactive lane takes no part in the request. Its address is not counted, its write is not performed and its `rd_data` entry keeps its previous value.
- R6: When lane k addresses word k*BANKS+j for a fixed j, every lane hits one bank and the request takes LANES passes.
- R7: `busy` rises on the edge that accepts a request with at least one active lane. While `busy` is high, `req_valid` and the lane inputs are ignored.
- R8: `done` is high for one cycle. In that cycle `busy` has just fallen. `done` appears exactly pass-count cycles after the accepting edge, and `pass_count` changes only together with `done`.
- R9: When several active lanes write the same address, the word stored is the data of the highest-numbered writing lane.
- R10: Every served lane, reading or writing, returns in `rd_data` the word held at its address before its pass. A read that is merged with a write to the same address sees the old word.
- R11: An accepted request with no active lane leaves `busy` low and gives `done` on the next cycle with `pass_count` equal to 0.
- R12: After reset `busy`, `done`, `pass_count` and every `rd_data` entry are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Offer a request; taken when idle |
| lane_act | input | LANES | Per-lane active bit |
| lane_addr | input | LANES x AW | Per-lane word address |
| lane_we | input | LANES | Per-lane write enable |
| lane_wdata | input | LANES x DW | Per-lane write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | LANES x DW | Per-lane read data, valid at `done` |
| pass_count | output | PW | Passes used by the last request |

## Verification
Broadcast merging and conflict replay can meet in the same bank and the same pass. A lane group sharing one address can be served together while another address in that bank waits for a later pass. The bench sets this up with mixed requests, in which duplicated addresses sit beside different addresses in one bank and some of the duplicates are writes. It judges the outcome against a shadow memory model. The model expects each bank to cost one pass per distinct address. Merged reads should return the word that was stored before the pass. The stored result should be the highest writing lane's data.

// File: rtl/lane_scratchpad.sv
module lane_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int AW    = 10,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = AW - BW,
  localparam int DEPTH = 1 << RW,
  localparam int PW   = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [LANES-1:0]             lane_act,
  input  logic [LANES-1:0][AW-1:0]     lane_addr,
  input  logic [LANES-1:0]             lane_we,
  input  logic [LANES-1:0][DW-1:0]     lane_wdata,
  output logic                         busy,
  output logic                         done,
  output logic [LANES-1:0][DW-1:0]     rd_data,
  output logic [PW-1:0]                pass_count
);

  logic [DW-1:0]           mem [BANKS][DEPTH];
  logic [LANES-1:0]        pend;
  logic [LANES-1:0][AW-1:0] q_addr;
  logic [LANES-1:0]        q_we;
  logic [LANES-1:0][DW-1:0] q_wd;
  logic [PW-1:0]           cnt;

  logic [AW-1:0]           lead_addr [BANKS];
  logic [LANES-1:0]        serve;
  logic [LANES-1:0]        left;
  logic [BANKS-1:0]        bwr;
  logic [DW-1:0]           bwd [BANKS];

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      lead_addr[b] = '0;
      for (int l = LANES - 1; l >= 0; l--)
        if (pend[l] && q_addr[l][BW-1:0] == BW'(b))
          lead_addr[b] = q_addr[l];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      serve[l] = pend[l] && (q_addr[l] == lead_addr[q_addr[l][BW-1:0]]);
  end

  assign left = pend & ~serve;

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bwr[b] = 1'b0;
      bwd[b] = '0;
      for (int l = 0; l < LANES; l++)
        if (serve[l] && q_we[l] && q_addr[l][BW-1:0] == BW'(b)) begin
          bwr[b] = 1'b1;
          bwd[b] = q_wd[l];
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++)
      if (bwr[b])
        mem[b][lead_addr[b][AW-1:BW]] <= bwd[b];
  end

  always_ff @(posedge clk) begin
    if (!busy && req_valid) begin
      q_addr <= lane_addr;
      q_we   <= lane_we;
      q_wd   <= lane_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (serve[l])
          rd_data[l] <= mem[q_addr[l][BW-1:0]][q_addr[l][AW-1:BW]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      pass_count <= '0;
      pend       <= '0;
      cnt        <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          pend <= lane_act;
          cnt  <= '0;
          if (|lane_act) begin
            busy <= 1'b1;
          end else begin
            done       <= 1'b1;
            pass_count <= '0;
          end
        end
      end else begin
        pend <= left;
        cnt  <= cnt + 1'b1;
        if (left == '0) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          pass_count <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lane_scratchpad_chk.sv
module lane_scratchpad_chk #(
  parameter int LANES = 32,
  parameter int PW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LANES-1:0] lane_act,
  input logic             busy,
  input logic             done,
  input logic [PW-1:0]    pass_count
);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && |lane_act) |=> busy);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_fall_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_count_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pass_count));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass_count <= PW'(LANES)));

  assert_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && lane_act == '0) |=> (done && pass_count == '0 && !busy));

endmodule

bind lane_scratchpad lane_scratchpad_chk #(.LANES(LANES), .PW(PW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .lane_act(lane_act),
  .busy(busy),
  .done(done),
  .pass_count(pass_count)
);

// File: tb/sim_lane_scratchpad.sv
module sim_lane_scratchpad;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int BANKS = 32;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int PW = 6;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LANES-1:0] lane_act = '0;
  logic [LANES-1:0][AW-1:0] lane_addr = '0;
  logic [LANES-1:0] lane_we = '0;
  logic [LANES-1:0][DW-1:0] lane_wdata = '0;
  logic busy, done;
  logic [LANES-1:0][DW-1:0] rd_data;
  logic [PW-1:0] pass_count;

  logic [DW-1:0] shadow [WORDS];
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_scratchpad u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lane_act(lane_act),
    .lane_addr(lane_addr), .lane_we(lane_we), .lane_wdata(lane_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .pass_count(pass_count)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic clear_lanes();
    lane_act = '0; lane_we = '0; lane_addr = '0; lane_wdata = '0;
  endtask

  // Issues the request held on the lane inputs and checks it against the shadow model.
  task automatic do_req(input string tag, input bit hold);
    int exp_pass, k, bad_lane;
    logic [DW-1:0] exp_rd [LANES];
    logic [LANES-1:0] act;
    logic [LANES-1:0][AW-1:0] adr;
    logic [LANES-1:0] we;
    logic [LANES-1:0][DW-1:0] wd;
    act = lane_act; adr = lane_addr; we = lane_we; wd = lane_wdata;
    exp_pass = 0;
    for (int b = 0; b < BANKS; b++) begin
      int n;
      n = 0;
      for (int l = 0; l < LANES; l++) begin
        bit seen;
        seen = 0;
        if (act[l] && int'(adr[l]) % BANKS == b) begin
          for (int j = 0; j < l; j++)
            if (act[j] && adr[j] == adr[l]) seen = 1;
          if (!seen) n++;
        end
      end
      if (n > exp_pass) exp_pass = n;
    end
    for (int l = 0; l < LANES; l++)
      exp_rd[l] = act[l] ? shadow[adr[l]] : rd_data[l];
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      lane_act = '1;
      for (int l = 0; l < LANES; l++) begin
        lane_addr[l] = AW'(l * 3 + 1);
        lane_we[l] = 1'b1;
        lane_wdata[l] = 32'hDEAD0000 + l;
      end
    end else begin
      req_valid = 1'b0;
    end
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    check(pass_count == PW'(exp_pass), tag, "pass_count", pass_count, exp_pass);
    check(k == exp_pass, "R8", "cycles to done", k, exp_pass);
    check(!busy, "R8", "busy at done", busy, 0);
    bad_lane = -1;
    for (int l = LANES - 1; l >= 0; l--)
      if (rd_data[l] !== exp_rd[l]) bad_lane = l;
    if (bad_lane >= 0)
      check(0, tag, $sformatf("rd_data lane %0d", bad_lane), rd_data[bad_lane], exp_rd[bad_lane]);
    else
      check(1, tag, "rd_data", 0, 0);
    for (int l = 0; l < LANES; l++)
      if (act[l] && we[l]) shadow[adr[l]] = wd[l];
    @(negedge clk);
    check(!done && !busy, "R8", "done single pulse", done, 0);
    clear_lanes();
  endtask

  task automatic t_reset();
    check(!busy && !done && pass_count == 0, "R12", "control after reset", {busy, done, pass_count}, 0);
    check(rd_data == '0, "R12", "rd_data after reset", rd_data[0], 0);
  endtask

  // R1 R2: fill every row with lanes in distinct banks
  task automatic t_fill();
    for (int r = 0; r < WORDS / BANKS; r++) begin
      lane_act = '1; lane_we = '1;
      for (int l = 0; l < LANES; l++) begin
        lane_addr[l] = AW'(r * BANKS + l);
        lane_wdata[l] = 32'h1000_0000 + r * 977 + l * 13;
      end
      do_req("R1", 1'b0);
    end
  endtask

  // R2 R5: shuffled banks, odd lanes inactive carrying writes
  task automatic t_shuffle();
    for (int l = 0; l < LANES; l++) begin
      lane_act[l] = (l % 2 == 0);
      lane_addr[l] = AW'((l * 7 + 3) % BANKS + BANKS * (l % 4));
      lane_we[l] = (l % 2 == 1);
      lane_wdata[l] = 32'hBAD0_0000 + l;
    end
    do_req("R2", 1'b0);
    lane_act = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'((l * 7 + 3) % BANKS + BANKS * (l % 4));
    do_req("R5", 1'b0);
  endtask

  task automatic t_broadcast();
    lane_act = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'(100);
    do_req("R4", 1'b0);
  endtask

  task automatic t_conflict();
    lane_act = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'(l + 64);
    lane_addr[0] = AW'(5); lane_addr[1] = AW'(37); lane_addr[2] = AW'(69); lane_addr[3] = AW'(5);
    do_req("R3", 1'b0);
  endtask

  task automatic t_strided();
    lane_act = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'(l * BANKS + 3);
    do_req("R6", 1'b0);
  endtask

  task automatic t_write_merge();
    lane_act[2] = 1; lane_act[9] = 1; lane_act[30] = 1;
    lane_we[2] = 1; lane_we[9] = 1; lane_we[30] = 1;
    lane_addr[2] = AW'(200); lane_addr[9] = AW'(200); lane_addr[30] = AW'(200);
    lane_wdata[2] = 32'hAAAA0002; lane_wdata[9] = 32'hAAAA0009; lane_wdata[30] = 32'hAAAA001E;
    do_req("R9", 1'b0);
    lane_act[0] = 1; lane_addr[0] = AW'(200);
    do_req("R9", 1'b0);
    check(rd_data[0] == 32'hAAAA001E, "R9", "highest writer stored", rd_data[0], 32'hAAAA001E);
  endtask

  task automatic t_read_write_same();
    lane_act[0] = 1; lane_we[0] = 1; lane_addr[0] = AW'(300); lane_wdata[0] = 32'h5555AAAA;
    lane_act[1] = 1; lane_addr[1] = AW'(300);
    lane_act[2] = 1; lane_addr[2] = AW'(300 + BANKS);
    do_req("R10", 1'b0);
    lane_act[5] = 1; lane_addr[5] = AW'(300);
    do_req("R10", 1'b0);
  endtask

  task automatic t_empty();
    lane_we = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'(l);
    do_req("R11", 1'b0);
  endtask

  task automatic t_busy_ignore();
    lane_act = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'((l % 4) * BANKS + 9);
    do_req("R7", 1'b1);
    lane_act = '1;
    for (int l = 0; l < LANES; l++) lane_addr[l] = AW'(l * 3 + 1);
    do_req("R7", 1'b0);
  endtask

  // R3 R4 R9 R10: random mixes with dense conflicts and merges
  task automatic t_random();
    int unsigned x;
    x = 32'h1234_5678;
    for (int it = 0; it < 24; it++) begin
      for (int l = 0; l < LANES; l++) begin
        x = x * 1103515245 + 12345;
        lane_act[l] = (x[20:18] != 0);
        lane_addr[l] = AW'((x >> 8) % 96);
        lane_we[l] = x[27];
        lane_wdata[l] = x;
      end
      do_req("R3", 1'b0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R8 watchdog: got %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_shuffle();
    t_broadcast();
    t_conflict();
    t_strided();
    t_write_merge();
    t_read_write_same();
    t_empty();
    t_busy_ignore();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule